// File: doc/BRIEF.md
# Banked Lane-Group Scratchpad

This block is an on-chip scratchpad whose storage is interleaved across as many banks as there are lanes in a request group (32 by default). One request carries, for every lane, an enable, a byte address, a write flag and write data. Each lane's address is turned into a word index, and the word index selects a bank and a row. All banks work in parallel every cycle. A group whose lanes touch distinct banks finishes in one cycle. A group that needs several different words from one bank is spread over as many cycles as that bank needs, and `busy` stays high for that whole time.

Lanes that read the same word share one access. Their data is broadcast and costs no extra cycle. When the group finishes, the block raises a one-cycle `done` and reports the number of cycles it took as the conflict degree. Each lane's read data sits in a register that is loaded in the cycle its word is served, and it stays there until the next request is accepted. A mode input selects 4-byte or 8-byte words. The mode changes both the address-to-bank mapping and the data width of each bank access.

Top module: `lane_scratchpad`

## Requirements
- R1: The word index is the byte address shifted right by 2 when `wide_mode`=0, and shifted right by 3 when `wide_mode`=1. The bank is the word index modulo NL and the row is the word index divided by NL. With 4-byte words, words 0 and 33 fall in different banks and complete in one cycle.
- R2: If all active lanes touch distinct banks, the group is served in a single busy cycle with degree 1. This holds for 32 consecutive words.
- R3: Different words that map to the same bank are served one per cycle. `busy` stays high for D cycles, where D is the largest number of distinct words requested in any one bank, and `degree` equals D while `done` is high. Words 0 and 32 give D=2. Lane i reading word (i·32) mod 1024 gives D=32.
- R4: Lanes that read the same word get that word from a single access. This adds nothing to D.
- R5: Within a bank, distinct words are served in ascending order of the lowest lane requesting each word. A lane's `lane_rdata` is zero from acceptance until its service cycle, then holds its value until the next acceptance.
- R6: If several lanes write one word, the highest-numbered writer's data is stored. Reads of that word in the same group return the data from before the group.
- R7: In 4-byte mode only bits [31:0] of the write data are stored, with the upper half cleared, and reads return zero in bits [63:32]. In 8-byte mode all 64 bits are stored and returned.
- R8: `req_valid` is ignored while `busy` is high. Nothing is latched and nothing is written.
- R9: Inactive lanes take no part in conflicts and read as zero. A group with no active lane takes one busy cycle and reports degree 0.
- R10: A request is accepted on a rising edge where `req_valid`=1 and `busy`=0. `busy` is high from the next cycle. `done` is a one-cycle pulse in the first cycle after `busy` falls. After reset `busy`, `done`, `degree` and all read data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Present a lane group |
| wide_mode | input | 1 | 0: 4-byte words, 1: 8-byte words |
| lane_en | input | NL | Per-lane enable |
| lane_wr | input | NL | Per-lane write flag |
| lane_addr | input | NL*ADDR_W | Per-lane byte address, lane i at bits [i*ADDR_W +: ADDR_W] |
| lane_wdata | input | NL*DATA_W | Per-lane write data |
| busy | output | 1 | Group in progress; new requests ignored |
| done | output | 1 | One-cycle completion pulse |
| degree | output | CNT_W | Cycles taken by the last group |
| lane_rdata | output | NL*DATA_W | Per-lane registered read data |

## Verification
If the pending set is corrupted, `busy` ends a cycle too early or too late, and `degree` differs from the model's maximum distinct-word count in the same `done` cycle. If the per-bank pick order is wrong, a lane's read data appears in the wrong service cycle, and the cycle-by-cycle comparison of every lane's read data shows this within one clock. A wrong write winner or a bad mode mask is stored silently, so it shows only when that word is read again in a later group, at that group's service cycle.

// File: rtl/spm_pkg.sv
// Shared definitions for the banked lane-group scratchpad.
// Assumes: nothing beyond the standard language.
package spm_pkg;

    // Word size selection carried by the wide_mode input.
    typedef enum logic {
        MODE_NARROW = 1'b0,   // 4-byte words
        MODE_WIDE   = 1'b1    // 8-byte words
    } word_mode_e;

endpackage

// File: rtl/spm_bank_pick.sv
// Per-bank selector. Among the pending lanes whose word falls in this bank,
// it picks the word of the lowest-numbered lane. It flags every pending lane
// that asks for that same word and names the highest-numbered writer of it.
// Assumes: the low BANK_W bits of a word index are its bank.
module spm_bank_pick #(
    parameter int NL      = 32,
    parameter int WORD_W  = 10,
    parameter int BANK_W  = 5,
    parameter int BANK_ID = 0,
    localparam int LANE_W = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic [NL-1:0]        pending,
    input  logic [NL-1:0]        lane_wr,
    input  logic [NL*WORD_W-1:0] lane_word,
    output logic [WORD_W-1:0]    sel_word,
    output logic [NL-1:0]        hit,
    output logic                 wr_en,
    output logic [LANE_W-1:0]    wr_lane
);

    logic sel_valid;

    // Lowest pending lane mapped to this bank sets the word served now.
    always_comb begin
        sel_valid = 1'b0;
        sel_word  = '0;
        for (int i = NL - 1; i >= 0; i--) begin
            if (pending[i] && lane_word[i*WORD_W +: BANK_W] == BANK_W'(BANK_ID)) begin
                sel_valid = 1'b1;
                sel_word  = lane_word[i*WORD_W +: WORD_W];
            end
        end
    end

    // Every pending lane asking for the chosen word shares this access.
    always_comb begin
        for (int i = 0; i < NL; i++) begin
            hit[i] = sel_valid && pending[i] && (lane_word[i*WORD_W +: WORD_W] == sel_word);
        end
    end

    // The last writer in lane order wins the store.
    always_comb begin
        wr_en   = 1'b0;
        wr_lane = '0;
        for (int i = 0; i < NL; i++) begin
            if (hit[i] && lane_wr[i]) begin
                wr_en   = 1'b1;
                wr_lane = LANE_W'(i);
            end
        end
    end

endmodule

// File: rtl/spm_bank_store.sv
// Storage of one bank: combinational read and synchronous write of one row
// per cycle, so a read in a write cycle returns the old contents.
// Assumes: contents are undefined until written; no reset on the array.
module spm_bank_store #(
    parameter int ROWS   = 32,
    parameter int DATA_W = 64,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [ROWS];

    // Present the addressed row for this cycle's service.
    assign rdata = mem[row];

    // Commit the winning write at the end of the service cycle.
    always_ff @(posedge clk) begin
        if (we) mem[row] <= wdata;
    end

endmodule

// File: rtl/lane_scratchpad.sv
// Banked scratchpad serving one lane group at a time. It latches a group,
// then serves one distinct word per bank per cycle until no lane is pending,
// then pulses done with the number of cycles used.
// Assumes: one group in flight; the mode is latched with the group.
module lane_scratchpad
    import spm_pkg::*;
#(
    parameter int NL     = 32,
    parameter int ROWS   = 32,
    parameter int DATA_W = 64,
    localparam int BANK_W = $clog2(NL),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int WORD_W = BANK_W + ROW_W,
    localparam int ADDR_W = WORD_W + 2,
    localparam int CNT_W  = $clog2(NL + 1),
    localparam int HALF_W = DATA_W / 2,
    localparam int LANE_W = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 wide_mode,
    input  logic [NL-1:0]        lane_en,
    input  logic [NL-1:0]        lane_wr,
    input  logic [NL*ADDR_W-1:0] lane_addr,
    input  logic [NL*DATA_W-1:0] lane_wdata,
    output logic                 busy,
    output logic                 done,
    output logic [CNT_W-1:0]     degree,
    output logic [NL*DATA_W-1:0] lane_rdata
);

    logic                          busy_q, done_q;
    logic [CNT_W-1:0]              degree_q, cnt_q;
    word_mode_e                    mode_q;
    logic [NL-1:0]                 pending_q, wr_q, served, pend_nxt;
    logic [NL-1:0][WORD_W-1:0]     word_q, word_in;
    logic [NL-1:0][DATA_W-1:0]     wdata_q, rdata_q;

    logic [WORD_W-1:0]             sel_w    [NL];
    logic [NL-1:0]                 bank_hit [NL];
    logic                          pick_we  [NL];
    logic [LANE_W-1:0]             pick_wl  [NL];
    logic [DATA_W-1:0]             bank_rd  [NL];
    logic [DATA_W-1:0]             st_wd    [NL];

    // Turn each lane's byte address into a word index for the selected mode.
    always_comb begin
        for (int i = 0; i < NL; i++) begin
            if (wide_mode == MODE_WIDE)
                word_in[i] = {1'b0, lane_addr[i*ADDR_W + 3 +: WORD_W - 1]};
            else
                word_in[i] = lane_addr[i*ADDR_W + 2 +: WORD_W];
        end
    end

    genvar b;
    generate
        for (b = 0; b < NL; b++) begin : g_bank
            spm_bank_pick #(
                .NL(NL), .WORD_W(WORD_W), .BANK_W(BANK_W), .BANK_ID(b)
            ) u_pick (
                .pending  (pending_q),
                .lane_wr  (wr_q),
                .lane_word(word_q),
                .sel_word (sel_w[b]),
                .hit      (bank_hit[b]),
                .wr_en    (pick_we[b]),
                .wr_lane  (pick_wl[b])
            );

            // Narrow mode keeps only the low half of the winning data.
            assign st_wd[b] = (mode_q == MODE_WIDE) ? wdata_q[pick_wl[b]]
                            : {{(DATA_W - HALF_W){1'b0}}, wdata_q[pick_wl[b]][HALF_W-1:0]};

            spm_bank_store #(.ROWS(ROWS), .DATA_W(DATA_W)) u_store (
                .clk  (clk),
                .we   (busy_q && pick_we[b]),
                .row  (sel_w[b][WORD_W-1 -: ROW_W]),
                .wdata(st_wd[b]),
                .rdata(bank_rd[b])
            );
        end
    endgenerate

    // Gather the lanes served by any bank this cycle.
    always_comb begin
        served = '0;
        for (int k = 0; k < NL; k++) served = served | bank_hit[k];
        pend_nxt = pending_q & ~served;
    end

    // Accept a group when idle, otherwise advance one service round.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            degree_q  <= '0;
            cnt_q     <= '0;
            mode_q    <= MODE_NARROW;
            pending_q <= '0;
            wr_q      <= '0;
            word_q    <= '0;
            wdata_q   <= '0;
            rdata_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (req_valid) begin
                    busy_q    <= 1'b1;
                    cnt_q     <= '0;
                    mode_q    <= word_mode_e'(wide_mode);
                    pending_q <= lane_en;
                    wr_q      <= lane_wr;
                    word_q    <= word_in;
                    wdata_q   <= lane_wdata;
                    rdata_q   <= '0;
                end
            end else begin
                pending_q <= pend_nxt;
                cnt_q     <= cnt_q + CNT_W'(|served);
                for (int i = 0; i < NL; i++) begin
                    if (served[i])
                        rdata_q[i] <= (mode_q == MODE_WIDE) ? bank_rd[word_q[i][BANK_W-1:0]]
                                    : {{(DATA_W - HALF_W){1'b0}}, bank_rd[word_q[i][BANK_W-1:0]][HALF_W-1:0]};
                end
                if (pend_nxt == '0) begin
                    busy_q   <= 1'b0;
                    done_q   <= 1'b1;
                    degree_q <= cnt_q + CNT_W'(|served);
                end
            end
        end
    end

    assign busy       = busy_q;
    assign done       = done_q;
    assign degree     = degree_q;
    assign lane_rdata = rdata_q;

    // R10: completion is a single-cycle pulse.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R8: while busy, no lane is added to the pending set.
    p_no_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> ((pending_q & ~$past(pending_q)) == '0));

    // R3: every busy cycle with work left serves at least one lane.
    p_progress_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && pending_q != '0) |=> ($countones(pending_q) < $countones($past(pending_q))));

    // R3: the reported degree never exceeds the lane count.
    p_degree_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (degree_q <= CNT_W'(NL)));

    // R9: nothing is left pending once idle.
    p_idle_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> (pending_q == '0));

    genvar l;
    generate
        for (l = 0; l < NL; l++) begin : g_hold
            // R5: read data of a lane not served this cycle stays put.
            p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (busy_q && !served[l]) |=> $stable(rdata_q[l]));
        end
    endgenerate

endmodule

// File: tb/test_lane_scratchpad.sv
module test_lane_scratchpad;

    localparam int NL = 32, ROWS = 32, DW = 64;
    localparam int AW = 12, CW = 6, WORDS = NL * ROWS;

    logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, wide_mode = 1'b0;
    logic [NL-1:0] lane_en = '0, lane_wr = '0;
    logic [NL*AW-1:0] lane_addr = '0;
    logic [NL*DW-1:0] lane_wdata = '0;
    logic busy, done;
    logic [CW-1:0] degree;
    logic [NL*DW-1:0] lane_rdata;

    always #10 clk = ~clk;

    lane_scratchpad #(.NL(NL), .ROWS(ROWS), .DATA_W(DW)) i_lane_scratchpad (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .wide_mode(wide_mode),
        .lane_en(lane_en), .lane_wr(lane_wr), .lane_addr(lane_addr),
        .lane_wdata(lane_wdata), .busy(busy), .done(done), .degree(degree),
        .lane_rdata(lane_rdata));

    int checks = 0, errors = 0;

    // Reference memory indexed by word number and the current stimulus.
    logic [63:0] mem_m [WORDS];
    bit          s_en [NL], s_wr [NL];
    int          s_addr [NL];
    logic [63:0] s_wd [NL];
    bit          s_wide;
    int          w_of [NL], rank [NL];
    logic [63:0] expd [NL];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_stim();
        for (int i = 0; i < NL; i++) begin
            s_en[i] = 0; s_wr[i] = 0; s_addr[i] = 0; s_wd[i] = '0;
        end
    endtask

    // Drive one group, follow it cycle by cycle against the model.
    task automatic issue(input string req, input bit hold_junk);
        int deg, d;
        logic [63:0] mask;
        mask = s_wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        deg = 0;
        for (int i = 0; i < NL; i++) w_of[i] = s_wide ? (s_addr[i] >> 3) : (s_addr[i] >> 2);
        for (int i = 0; i < NL; i++) begin
            int f, r;
            rank[i] = 0;
            expd[i] = '0;
            if (!s_en[i]) continue;
            f = i;
            for (int j = 0; j < i; j++)
                if (s_en[j] && w_of[j] == w_of[i]) begin f = j; break; end
            r = 1;
            for (int j = 0; j < f; j++) begin
                bit lead;
                lead = s_en[j];
                for (int k = 0; k < j; k++)
                    if (s_en[k] && w_of[k] == w_of[j]) lead = 0;
                if (lead && (w_of[j] % NL) == (w_of[i] % NL)) r++;
            end
            rank[i] = r;
            expd[i] = mem_m[w_of[i]] & mask;
            if (r > deg) deg = r;
        end
        wide_mode = s_wide;
        for (int i = 0; i < NL; i++) begin
            lane_en[i] = s_en[i];
            lane_wr[i] = s_wr[i];
            lane_addr[i*AW +: AW] = AW'(s_addr[i]);
            lane_wdata[i*DW +: DW] = s_wd[i];
        end
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (hold_junk) begin
            // Junk group with all lanes writing; must be ignored (R8).
            wide_mode = 1'b0;
            lane_en = '1;
            lane_wr = '1;
            for (int i = 0; i < NL; i++) begin
                lane_addr[i*AW +: AW] = AW'(i * 4);
                lane_wdata[i*DW +: DW] = '1;
            end
        end else begin
            req_valid = 1'b0;
        end
        d = (deg < 1) ? 1 : deg;
        for (int k = 0; k <= d; k++) begin
            int bad;
            if (k == d) req_valid = 1'b0;
            chk(busy == (k < d), req, $sformatf("busy at step %0d", k), 64'(busy), 64'(k < d));
            chk(done == (k == d), req, $sformatf("done at step %0d", k), 64'(done), 64'(k == d));
            bad = -1;
            for (int i = 0; i < NL; i++) begin
                logic [63:0] e;
                e = (s_en[i] && rank[i] <= k) ? expd[i] : 64'h0;
                if (lane_rdata[i*DW +: DW] !== e && bad < 0) bad = i;
            end
            if (bad >= 0) begin
                logic [63:0] e;
                e = (s_en[bad] && rank[bad] <= k) ? expd[bad] : 64'h0;
                chk(0, req, $sformatf("rdata lane %0d step %0d", bad, k),
                    lane_rdata[bad*DW +: DW], e);
            end else begin
                chk(1, req, "rdata", '0, '0);
            end
            if (k == d)
                chk(degree == CW'(deg), req, "degree", 64'(degree), 64'(deg));
            else
                @(negedge clk);
        end
        for (int i = 0; i < NL; i++)
            if (s_en[i] && s_wr[i]) mem_m[w_of[i]] = s_wd[i] & mask;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        // R10: reset state.
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R10", "busy after reset", 64'(busy), 0);
        chk(done == 1'b0, "R10", "done after reset", 64'(done), 0);
        chk(degree == '0, "R10", "degree after reset", 64'(degree), 0);
        chk(lane_rdata == '0, "R10", "rdata after reset", lane_rdata[63:0], 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2, R7: fill all words in 4-byte mode; upper halves must be dropped.
        s_wide = 0;
        for (int blk = 0; blk < ROWS; blk++) begin
            clear_stim();
            for (int i = 0; i < NL; i++) begin
                s_en[i] = 1; s_wr[i] = 1; s_addr[i] = (blk * NL + i) * 4;
                s_wd[i] = {32'h5A5A_0000 + 32'(blk), 32'hC000_0000 + 32'((blk * NL + i) * 13)};
            end
            issue("R2", 0);
        end

        // R2: consecutive-word read.
        clear_stim();
        for (int i = 0; i < NL; i++) begin s_en[i] = 1; s_addr[i] = (100 + i) * 4; end
        issue("R2", 0);

        // R1: words 0 and 33 fall in different banks.
        clear_stim();
        s_en[0] = 1; s_addr[0] = 0; s_en[1] = 1; s_addr[1] = 132;
        issue("R1", 0);

        // R3: words 0 and 32 share bank 0.
        clear_stim();
        s_en[0] = 1; s_addr[0] = 0; s_en[1] = 1; s_addr[1] = 128;
        issue("R3", 0);

        // R3: stride of 32 words puts every lane in bank 0.
        clear_stim();
        for (int i = 0; i < NL; i++) begin s_en[i] = 1; s_addr[i] = ((i * 32) % WORDS) * 4; end
        issue("R3", 0);

        // R4: all lanes read one word.
        clear_stim();
        for (int i = 0; i < NL; i++) begin s_en[i] = 1; s_addr[i] = 5 * 4; end
        issue("R4", 0);

        // R4: two broadcast groups in one bank give degree 2.
        clear_stim();
        for (int i = 0; i < NL; i++) begin s_en[i] = 1; s_addr[i] = (i < 16) ? 7 * 4 : 39 * 4; end
        issue("R4", 0);

        // R5: order within bank 0 follows the lowest requesting lane.
        clear_stim();
        s_en[3] = 1; s_addr[3] = 64 * 4;
        s_en[1] = 1; s_addr[1] = 32 * 4;
        s_en[5] = 1; s_addr[5] = 64 * 4;
        s_en[7] = 1; s_addr[7] = 0;
        issue("R5", 0);

        // R6: several writers to one word plus a reader in the same group.
        clear_stim();
        for (int i = 0; i < 4; i++) begin
            s_en[i] = 1; s_wr[i] = 1; s_addr[i] = 10 * 4; s_wd[i] = 64'(32'h1111_0000 + i);
        end
        s_en[4] = 1; s_addr[4] = 10 * 4;
        issue("R6", 0);
        clear_stim();
        s_en[9] = 1; s_addr[9] = 10 * 4;
        issue("R6", 0);

        // R9: empty group, then a sparse group.
        clear_stim();
        issue("R9", 0);
        clear_stim();
        s_en[2] = 1; s_addr[2] = 300 * 4; s_en[30] = 1; s_addr[30] = 301 * 4;
        issue("R9", 0);

        // R8: requests held during busy must be ignored, memory untouched.
        clear_stim();
        for (int i = 0; i < NL; i++) begin s_en[i] = 1; s_addr[i] = ((i * 32) % WORDS) * 4; end
        issue("R8", 1);
        clear_stim();
        for (int i = 0; i < NL; i++) begin s_en[i] = 1; s_addr[i] = i * 4; end
        issue("R8", 0);

        // R7, R1: 8-byte mode writes and reads.
        s_wide = 1;
        for (int blk = 0; blk < 2; blk++) begin
            clear_stim();
            for (int i = 0; i < NL; i++) begin
                s_en[i] = 1; s_wr[i] = 1; s_addr[i] = (blk * NL + i) * 8;
                s_wd[i] = {32'hBEEF_0000 + 32'(i), 32'h0F00_0000 + 32'(blk * 97 + i)};
            end
            issue("R7", 0);
        end
        clear_stim();
        for (int i = 0; i < NL; i++) begin s_en[i] = 1; s_addr[i] = (NL - 1 - i) * 8; end
        issue("R7", 0);
        clear_stim();
        s_en[0] = 1; s_addr[0] = 0; s_en[1] = 1; s_addr[1] = 256;
        issue("R1", 0);
        clear_stim();
        s_en[0] = 1; s_addr[0] = 0; s_en[1] = 1; s_addr[1] = 264;
        issue("R1", 0);

        // R7: 4-byte read of words written in 8-byte mode shows the low half only.
        s_wide = 0;
        clear_stim();
        for (int i = 0; i < NL; i++) begin s_en[i] = 1; s_addr[i] = (NL + i) * 4; end
        issue("R7", 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule